// File: doc/BRIEF.md
# Watchdog and Reset Pulse Sequencer

This block is the digital sequencing core of a processor supervisor. It takes a supply-good flag from an external comparator, a watchdog kick line driven by software, and a power-fail comparator flag. It drives a reset pair: one output is active low and the other is active high. It also drives an active-low power-fail warning.

Any change of level on the kick line restarts a watchdog timer. If the kick line stays at one level for the whole timeout window, the block asserts reset for a fixed stretch time. A bad supply holds reset for as long as it lasts. Once the supply is good again, reset stays asserted for the same stretch time before it releases. One stretch counter serves both causes.

The asynchronous block reset puts the sequencer into the reset-asserted state, so every power-on ends with a full stretch. The timeout and stretch lengths are derived from the clock frequency and two durations in milliseconds. Both can be overridden as cycle counts.

Top module: `svs_reset_seq`

## Requirements
- R1: A rising or falling edge on `kick_i` restarts the watchdog. The count is cleared on the third clock edge after the input changes, because of two synchronizer stages and one edge register. Kick gaps of up to `TIMEOUT_CYC` cycles therefore never cause a reset.
- R2: After reset releases, if `kick_i` does not change, reset is asserted on the `TIMEOUT_CYC`-th clock edge after the release edge.
- R3: A reset caused by the watchdog keeps `rst_no` low for exactly `PULSE_CYC` clock cycles while the supply stays good.
- R4: When `supply_ok_i` goes low, `rst_no` is low after the third clock edge. It stays low for as long as `supply_ok_i` is low.
- R5: When `supply_ok_i` returns high, `rst_no` goes high on the (`PULSE_CYC`+2)-th clock edge after the change.
- R6: `rst_o` is always the exact inverse of `rst_no`.
- R7: `pwr_fail_no` equals the inverse of `pwr_low_i`, delayed by two clock edges. A 1 on `pwr_low_i` means the monitored input is below its reference.
- R8: The watchdog is cleared and held while reset is asserted. Kick edges during reset are ignored. The timeout of R2 is counted from the release edge.
- R9: A supply drop during a watchdog reset pulse holds reset. The full stretch restarts from the supply's recovery, so release comes `PULSE_CYC`+2 edges after `supply_ok_i` rises.
- R10: While `rst_ni` is low, `rst_no`=0, `rst_o`=1 and `pwr_fail_no`=1. With `supply_ok_i` high, `rst_no` rises on the (`PULSE_CYC`+2)-th edge after `rst_ni` releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Supply comparator flag, 1 = supply above threshold |
| kick_i | input | 1 | Watchdog kick, either edge restarts the timer |
| pwr_low_i | input | 1 | Power-fail comparator flag, 1 = monitored input below reference |
| rst_no | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| pwr_fail_no | output | 1 | Power-fail warning, active low |

## Verification
A watchdog count that is not cleared on a kick edge shows up as a spurious reset within one timeout window of a legal kick pattern. A count that keeps running during reset moves the next expiry earlier by as many cycles as the pulse lasted. A stretch counter that is not restarted by a brown-out, or that starts one cycle late, changes the measured release edge by at least one cycle. The bench measures each release exactly to the edge. Synchronizer errors shift every latency by whole cycles: three edges to assertion, and the stretch plus two edges to release.

// File: rtl/svs_pkg.sv
package svs_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } seq_state_e;

  function automatic int unsigned ms_to_cyc(input int unsigned clk_hz, input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction
endpackage

// File: rtl/svs_sync.sv
module svs_sync #(
  parameter int unsigned          WIDTH   = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= src;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/svs_watchdog.sv
module svs_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 16,
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_s_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic          kick_prev_q;
  logic          kick_edge;
  logic [TW-1:0] wd_cnt_q;

  assign kick_edge = kick_s_i ^ kick_prev_q;
  assign expire_o  = !hold_i && !kick_edge && (wd_cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_prev_q <= 1'b0;
    else         kick_prev_q <= kick_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           wd_cnt_q <= '0;
    else if (hold_i || kick_edge || expire_o) wd_cnt_q <= '0;
    else                                   wd_cnt_q <= wd_cnt_q + 1'b1;
  end

  AST_WD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_cnt_q < TW'(TIMEOUT_CYC)) else $error("wd count out of range"); // R2
  AST_WD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> wd_cnt_q == '0) else $error("wd not held in reset"); // R8
  AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_s_i != kick_prev_q) |=> wd_cnt_q == '0) else $error("kick did not clear"); // R1
  AST_EXPIRE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !hold_i) else $error("expiry during hold"); // R8
endmodule

// File: rtl/svs_stretch.sv
module svs_stretch
  import svs_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 10,
  localparam int unsigned PW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic trigger_i,
  output logic in_reset_o
);
  localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

  seq_state_e    state_q;
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else if (!supply_ok_i) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (cnt_q == LAST) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (trigger_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
          end
        end
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign in_reset_o = (state_q == ST_HOLD);

  AST_BAD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> in_reset_o && cnt_q == '0) else $error("bad supply not held"); // R4
  AST_RELEASE_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_reset_o) |-> $past(supply_ok_i)) else $error("release on bad supply"); // R5
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < PW'(PULSE_CYC)) else $error("stretch count out of range"); // R3
  AST_TRIG_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trigger_i && supply_ok_i) |=> in_reset_o) else $error("trigger ignored"); // R2
endmodule

// File: rtl/svs_reset_seq.sv
module svs_reset_seq
  import svs_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned TIMEOUT_MS  = 1600,
  parameter int unsigned PULSE_MS    = 200,
  parameter int unsigned TIMEOUT_CYC = ms_to_cyc(CLK_HZ, TIMEOUT_MS),
  parameter int unsigned PULSE_CYC   = ms_to_cyc(CLK_HZ, PULSE_MS),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic kick_i,
  input  logic pwr_low_i,
  output logic rst_no,
  output logic rst_o,
  output logic pwr_fail_no
);
  logic [2:0] raw, synced;
  logic       supply_ok_s, kick_s, pwr_low_s;
  logic       expire, in_reset;

  assign raw = {pwr_low_i, kick_i, supply_ok_i};

  svs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign supply_ok_s = synced[0];
  assign kick_s      = synced[1];
  assign pwr_low_s   = synced[2];

  svs_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_s_i(kick_s),
    .hold_i  (in_reset),
    .expire_o(expire)
  );

  svs_stretch #(.PULSE_CYC(PULSE_CYC)) u_str (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_s),
    .trigger_i  (expire),
    .in_reset_o (in_reset)
  );

  assign rst_no      = !in_reset;
  assign rst_o       = in_reset;
  assign pwr_fail_no = !pwr_low_s;

  AST_RST_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o != rst_no) else $error("reset pair not complementary"); // R6
endmodule

// File: tb/tb_svs_reset_seq.sv
module tb_svs_reset_seq;
  localparam int unsigned TO = 16;
  localparam int unsigned PW = 10;
  localparam int NV = 8;
  localparam int unsigned GAP [NV] = '{1, 2, 7, TO-1, TO, 3, TO, TO+3};
  localparam logic        EXP [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok_i = 1'b1;
  logic kick_i = 1'b0;
  logic pwr_low_i = 1'b0;
  logic rst_no, rst_o, pwr_fail_no;
  int   checks = 0;
  int   errors = 0;
  int   inv_bad = 0;
  int   n;

  always #2.5 clk = ~clk;

  svs_reset_seq #(.TIMEOUT_CYC(TO), .PULSE_CYC(PW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i), .kick_i(kick_i),
    .pwr_low_i(pwr_low_i), .rst_no(rst_no), .rst_o(rst_o), .pwr_fail_no(pwr_fail_no)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst_o == rst_no) inv_bad++;
    end
  endtask

  task automatic count_until(input logic lvl, output int cnt);
    cnt = 0;
    do begin
      step(1);
      cnt++;
    end while (rst_no != lvl && cnt < 400);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10 reset state
    #12;
    check("R10 rst_no in reset", rst_no, 0);
    check("R10 rst_o in reset", rst_o, 1);
    check("R10 pwr_fail_no in reset", pwr_fail_no, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    count_until(1'b1, n);
    check("R10 power-on stretch", n, PW + 2);

    // R1 vector table: toggle then wait gap, check level
    for (int v = 0; v < NV; v++) begin
      kick_i = ~kick_i;
      step(GAP[v]);
      check($sformatf("R1 gap %0d", GAP[v]), rst_no, EXP[v]);
    end

    // R3 watchdog pulse width (pulse just began)
    count_until(1'b1, n);
    check("R3 watchdog pulse width", n, PW);
    // R2 timeout from release
    count_until(1'b0, n);
    check("R2 timeout after release", n, TO);

    // R8 kicks during pulse ignored, timer held
    n = 0;
    do begin
      step(1);
      n++;
      if (n == 2 || n == 4) kick_i = ~kick_i;
    end while (rst_no != 1'b1 && n < 400);
    check("R8 pulse with kicks", n, PW);
    count_until(1'b0, n);
    check("R8 timeout counted from release", n, TO);

    // R9 supply drop inside watchdog pulse
    step(2);
    supply_ok_i = 1'b0;
    step(6);
    check("R9 held during drop", rst_no, 0);
    supply_ok_i = 1'b1;
    count_until(1'b1, n);
    check("R9 restart from recovery", n, PW + 2);

    // R4 brown-out assertion latency and hold
    supply_ok_i = 1'b0;
    count_until(1'b0, n);
    check("R4 assert latency", n, 3);
    step(40);
    check("R4 held while bad", rst_no, 0);
    supply_ok_i = 1'b1;
    count_until(1'b1, n);
    check("R5 release after recovery", n, PW + 2);

    // R7 power-fail path
    pwr_low_i = 1'b1;
    step(1);
    check("R7 still high after 1 edge", pwr_fail_no, 1);
    step(1);
    check("R7 low after 2 edges", pwr_fail_no, 0);
    pwr_low_i = 1'b0;
    step(2);
    check("R7 high again", pwr_fail_no, 1);

    check("R6 rst_o inverse of rst_no", inv_bad, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule